// File: doc/BRIEF.md
# Dual-clock FIFO with programmable flags

This block is a single-direction first-in first-out buffer whose write side and read side run on clocks that are unrelated to each other. Each side moves one word per rising edge of its own clock when its enable is high. The write and read pointers are passed across the clock boundary as Gray code through two-flop synchronizers. Full and Almost-Full are derived in the write domain, and Empty and Almost-Empty in the read domain. A pair of these buffers, one for each direction, forms a bidirectional buffer.

The two "almost" thresholds can be set at run time through a small strobe-and-address register port on the write clock. Almost-Empty warns a reader that few words remain. Almost-Full warns a writer that little space remains. Both thresholds come out of reset at 8. Read data is registered and holds its value until the next accepted read.

Top module: `dcfifo_prog_flags`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `empty` and `almost_empty` are 1 and `full` and `almost_full` are 0.
- R2: Words leave in the order they were accepted. The word taken by a read accepted at a `rd_clk` rising edge is on `rd_data` after that same edge, and it stays there until the next accepted read.
- R3: A write is accepted at a `wr_clk` rising edge only when `wr_en` is 1 and `full` is 0. An accepted write stores `wr_data` and advances the write pointer by one.
- R4: A write attempted while `full` is 1 is ignored. No word is stored and the write pointer does not move.
- R5: A read attempted while `empty` is 1 is ignored. `rd_data` keeps its value and the read pointer does not move.
- R6: `full` is 1 exactly when the occupancy seen in the write domain equals DEPTH (256 by default).
- R7: `empty` is 1 exactly when the occupancy seen in the read domain is zero.
- R8: `almost_empty` is 1 when the occupancy seen in the read domain is at or below the empty threshold.
- R9: `almost_full` is 1 when the free space seen in the write domain (DEPTH minus occupancy) is at or below the full threshold.
- R10: When `cfg_sel` and `cfg_we` are both 1 at a `wr_clk` rising edge, `cfg_data` loads the empty threshold if `cfg_addr` is 0 and the full threshold if `cfg_addr` is 1. With `cfg_sel` at 0 the port is ignored. Reset sets both thresholds to 8, and they may take any value from 0 to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH (18) | Word to store |
| full | output | 1 | No free entry (write domain) |
| almost_full | output | 1 | Free space at or below the full threshold |
| cfg_sel | input | 1 | Threshold port select |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_addr | input | 1 | 0 selects the empty threshold, 1 selects the full threshold |
| cfg_data | input | clog2(DEPTH)+1 | Threshold value |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH (18) | Registered read word |
| empty | output | 1 | Nothing to read (read domain) |
| almost_empty | output | 1 | Occupancy at or below the empty threshold |

## Verification
The hardest case to reach from the ports is a write attempted at the moment the buffer is exactly full. A wrongly accepted write would only show up later, as an overwritten oldest entry or a corrupted occupancy. The stimulus fills the buffer to DEPTH entries, lets the synchronizers settle, and forces a write with a distinctive marker word. It then drains all DEPTH entries through the scoreboard, so the first word read back exposes any overwrite. Each threshold boundary is also approached one word at a time, with settling pauses in between, so every flag is sampled on both sides of its exact switching occupancy.

// File: rtl/dcfifo_prog_flags.sv
module dcfifo_prog_flags #(
  parameter int WIDTH       = 18,
  parameter int DEPTH       = 256,
  parameter int OFF_DEFAULT = 8
) (
  input  logic                     rst_n,
  input  logic                     wr_clk,
  input  logic                     wr_en,
  input  logic [WIDTH-1:0]         wr_data,
  output logic                     full,
  output logic                     almost_full,
  input  logic                     cfg_sel,
  input  logic                     cfg_we,
  input  logic                     cfg_addr,
  input  logic [$clog2(DEPTH):0]   cfg_data,
  input  logic                     rd_clk,
  input  logic                     rd_en,
  output logic [WIDTH-1:0]         rd_data,
  output logic                     empty,
  output logic                     almost_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] OFF_P   = PW'(OFF_DEFAULT);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_w1, rgray_w2, wgray_r1, wgray_r2;
  logic [PW-1:0] ae_off, af_off;

  wire [PW-1:0] wbin_nx = wbin + 1'b1;
  wire [PW-1:0] rbin_nx = rbin + 1'b1;
  wire [PW-1:0] wcount  = wbin - g2b(rgray_w2);
  wire [PW-1:0] rcount  = g2b(wgray_r2) - rbin;
  wire          wr_go   = wr_en & ~full;
  wire          rd_go   = rd_en & ~empty;

  assign full         = (wcount == DEPTH_P);
  assign almost_full  = ((DEPTH_P - wcount) <= af_off);
  assign empty        = (rcount == '0);
  assign almost_empty = (rcount <= ae_off);

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_go) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end

  always_ff @(posedge wr_clk)
    if (wr_go) mem[wbin[AW-1:0]] <= wr_data;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      rgray_w1 <= '0;
      rgray_w2 <= '0;
    end else begin
      rgray_w1 <= rgray;
      rgray_w2 <= rgray_w1;
    end

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      ae_off <= OFF_P;
      af_off <= OFF_P;
    end else if (cfg_sel && cfg_we) begin
      if (cfg_addr) af_off <= cfg_data;
      else          ae_off <= cfg_data;
    end

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_go) begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      wgray_r1 <= '0;
      wgray_r2 <= '0;
    end else begin
      wgray_r1 <= wgray;
      wgray_r2 <= wgray_r1;
    end

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n)     rd_data <= '0;
    else if (rd_go) rd_data <= mem[rbin[AW-1:0]];
endmodule

// File: rtl/dcfifo_prog_flags_chk.sv
module dcfifo_prog_flags_chk #(
  parameter int WIDTH = 18,
  parameter int PW    = 9
) (
  input logic             rst_n,
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             wr_en,
  input logic             rd_en,
  input logic             full,
  input logic             almost_full,
  input logic             empty,
  input logic             almost_empty,
  input logic [PW-1:0]    wbin,
  input logic [PW-1:0]    rbin,
  input logic [WIDTH-1:0] rd_data
);
  // R3
  wr_advance_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && !full) |=> (wbin == $past(wbin) + 1'b1));

  // R4
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && full) |=> $stable(wbin));

  // R5
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en && empty) |=> ($stable(rbin) && $stable(rd_data)));

  // R2
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !(rd_en && !empty) |=> $stable(rd_data));

  // R9
  full_implies_af_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full |-> almost_full);

  // R8
  empty_implies_ae_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    empty |-> almost_empty);
endmodule

bind dcfifo_prog_flags dcfifo_prog_flags_chk #(.WIDTH(WIDTH), .PW(PW)) u_chk (
  .rst_n(rst_n), .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_en(wr_en), .rd_en(rd_en),
  .full(full), .almost_full(almost_full), .empty(empty), .almost_empty(almost_empty),
  .wbin(wbin), .rbin(rbin), .rd_data(rd_data)
);

// File: tb/dcfifo_prog_flags_bench.sv
module dcfifo_prog_flags_bench;
  localparam int CLK_PERIOD    = 10;
  localparam int RD_CLK_PERIOD = 14;
  localparam int WIDTH = 18;
  localparam int DEPTH = 256;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic rst_n = 0, wr_clk = 0, rd_clk = 0;
  logic wr_en = 0, rd_en = 0;
  logic cfg_sel = 0, cfg_we = 0, cfg_addr = 0;
  logic [PW-1:0] cfg_data = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic full, almost_full, empty, almost_empty;

  int n_tests = 0, n_fail = 0, n_popped = 0;
  bit done = 0, rd_expect = 0;
  logic [WIDTH-1:0] sb_q[$];
  logic [WIDTH-1:0] seed = 18'h00101;

  always #(CLK_PERIOD/2)    wr_clk = ~wr_clk;
  always #(RD_CLK_PERIOD/2) rd_clk = ~rd_clk;

  dcfifo_prog_flags #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dcfifo_prog_flags (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
    .full(full), .almost_full(almost_full),
    .cfg_sel(cfg_sel), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data),
    .empty(empty), .almost_empty(almost_empty));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic push_word();
    @(negedge wr_clk);
    if (!full) begin
      seed = seed * 18'd5 + 18'd3;
      wr_en = 1; wr_data = seed;
      sb_q.push_back(seed);
    end
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) push_word();
  endtask

  task automatic force_write(input logic [WIDTH-1:0] d);
    @(negedge wr_clk);
    wr_en = 1; wr_data = d;
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic pop_word();
    @(negedge rd_clk);
    if (!empty) begin
      rd_en = 1; rd_expect = 1;
    end
    @(negedge rd_clk);
    rd_en = 0; rd_expect = 0;
  endtask

  task automatic drain();
    while (sb_q.size() > 0) pop_word();
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic cfg_write(input bit sel, input bit addr, input int val);
    @(negedge wr_clk);
    cfg_sel = sel; cfg_we = 1; cfg_addr = addr; cfg_data = PW'(val);
    @(negedge wr_clk);
    cfg_sel = 0; cfg_we = 0;
  endtask

  // Monitor: compare each accepted read with the scoreboard head (R2)
  always @(posedge rd_clk) begin
    if (rd_expect) begin
      #2;
      if (sb_q.size() == 0) chk(0, "R2 unexpected read", 1, 0);
      else begin
        logic [WIDTH-1:0] exp_w;
        exp_w = sb_q.pop_front();
        chk(rd_data == exp_w, "R2 read order", int'(rd_data), int'(exp_w));
        n_popped++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    logic [WIDTH-1:0] held;
    #40;
    // R1 during reset
    chk(empty == 1 && almost_empty == 1, "R1 empty flags in reset", int'({empty, almost_empty}), 3);
    chk(full == 0 && almost_full == 0, "R1 full flags in reset", int'({full, almost_full}), 0);
    rst_n = 1;
    settle();
    chk(empty && almost_empty && !full && !almost_full, "R1 after release",
        int'({empty, almost_empty, full, almost_full}), 12);

    // R3 R7 R8: small burst
    push_n(5);
    settle();
    chk(empty == 0, "R7 not empty with 5", int'(empty), 0);
    chk(almost_empty == 1, "R8 ae with 5 <= 8", int'(almost_empty), 1);
    drain();
    settle();
    chk(empty == 1, "R7 empty after drain", int'(empty), 1);

    // R8 default threshold boundary
    push_n(8);
    settle();
    chk(almost_empty == 1, "R8 ae at 8", int'(almost_empty), 1);
    push_n(1);
    settle();
    chk(almost_empty == 0, "R8 ae at 9", int'(almost_empty), 0);
    drain();
    settle();

    // R10 programmed empty threshold, deselected write ignored
    cfg_write(1, 0, 20);
    cfg_write(0, 0, 3);
    push_n(20);
    settle();
    chk(almost_empty == 1, "R10 ae at 20 with threshold 20", int'(almost_empty), 1);
    push_n(1);
    settle();
    chk(almost_empty == 0, "R10 ae at 21 with threshold 20", int'(almost_empty), 0);
    drain();
    settle();

    // R9 R10 programmed full threshold
    cfg_write(1, 1, 30);
    push_n(DEPTH - 31);
    settle();
    chk(almost_full == 0, "R9 af with free 31", int'(almost_full), 0);
    push_n(1);
    settle();
    chk(almost_full == 1, "R9 af with free 30", int'(almost_full), 1);

    // R6 full boundary
    push_n(29);
    settle();
    chk(full == 0, "R6 not full at DEPTH-1", int'(full), 0);
    push_n(1);
    settle();
    chk(full == 1, "R6 full at DEPTH", int'(full), 1);

    // R4 write while full is ignored
    force_write(18'h3ABCD);
    settle();
    chk(full == 1, "R4 still full after blocked write", int'(full), 1);
    chk(sb_q.size() == DEPTH, "R4 scoreboard depth", sb_q.size(), DEPTH);
    drain();
    settle();
    chk(empty == 1 && full == 0, "R4 empty after draining DEPTH", int'({empty, full}), 2);

    // R5 read while empty is ignored
    held = rd_data;
    @(negedge rd_clk); rd_en = 1;
    repeat (3) @(negedge rd_clk);
    rd_en = 0;
    settle();
    chk(rd_data == held, "R5 rd_data held", int'(rd_data), int'(held));
    chk(empty == 1, "R5 still empty", int'(empty), 1);
    push_n(1);
    settle();
    drain();
    settle();

    // R8 R10 threshold zero
    cfg_write(1, 0, 0);
    push_n(1);
    settle();
    chk(almost_empty == 0, "R8 ae threshold 0 with 1 word", int'(almost_empty), 0);
    drain();
    settle();
    chk(almost_empty == 1, "R8 ae threshold 0 when empty", int'(almost_empty), 1);

    // R2 R3 concurrent streaming
    n_popped = 0;
    fork
      push_n(40);
      while (n_popped < 40) pop_word();
    join
    settle();
    chk(sb_q.size() == 0 && empty == 1, "R2 stream fully delivered", sb_q.size(), 0);

    summary();
  end
endmodule